// File: doc/BRIEF.md
# Programmable Clock Divider Chain with Secondary Output Select

This block holds the digital part of a frequency synthesiser's clock path. From a reference clock it makes the slow compare clock that the phase detector uses on its reference side. From the oscillator-rate clock it makes the feedback compare clock and the primary output clock. It also picks what the secondary output carries. The phase detector, the charge pump and the oscillator are outside this block; a stimulus clock stands in for the oscillator.

Each ratio is written as a small offset-coded word, so the encodings that cannot be used are never reachable. Configuration words may change while the clocks run. A running counter always finishes its present period with the ratio it had, and only then takes the new one, so no output ever shows a runt pulse. An active-low power-down input forces both outputs low and drops the output-enable.

Top module: `clkgen_divchain`

## Requirements
- R1: `refcmp_o` repeats every `ref_div_i`+2 cycles of `ref_clk`. It is high for ceil(N/2) of those cycles and low for floor(N/2), where N is the ratio.
- R2: `fbcmp_o` repeats every `fb_div_i`+8 cycles of `vco_clk`, with the same high/low split as R1.
- R3: The internal primary clock repeats every `out_div_i`+2 cycles of `vco_clk`, with the same split as R1. `clk1_o` shows it while `pd_n` is 1.
- R4: An even ratio gives equal high and low phases. An odd ratio gives a high phase one source cycle longer than the low phase.
- R5: A ratio word that changes in mid-period has no effect on that period. The new ratio starts at the next rising edge of the output, which is where the counter wraps.
- R6: With `clk2_fn_i` = 2'b00, `clk2_o` follows `ref_clk`.
- R7: With `clk2_fn_i` = 2'b01, `clk2_o` is `ref_clk` divided by 2: one reference cycle high, then one low.
- R8: With `clk2_fn_i` = 2'b10, `clk2_o` stays low.
- R9: With `clk2_fn_i` = 2'b11, `clk2_o` is the primary clock divided by 2. It is high for N oscillator cycles and low for N, and each of its rising edges falls on a rising edge of the primary clock.
- R10: While `pd_n` is 0, `clk1_o`, `clk2_o` and `clk_oe_o` are 0, and the compare clocks keep running.
- R11: While `rst_n` is 0, `refcmp_o`, `fbcmp_o`, `clk1_o` and `clk2_o` are 0 (with `clk2_fn_i` = 2'b10), and `clk_oe_o` follows `pd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pd_n | input | 1 | Active-low power-down for the outputs |
| ref_div_i | input | 7 | Reference ratio word; ratio = word + 2 |
| fb_div_i | input | 9 | Feedback ratio word; ratio = word + 8 |
| out_div_i | input | 3 | Primary output ratio word; ratio = word + 2 |
| clk2_fn_i | input | 2 | Secondary output function: 00 ref, 01 ref/2, 10 low, 11 primary/2 |
| refcmp_o | output | 1 | Reference compare clock |
| fbcmp_o | output | 1 | Feedback compare clock |
| clk1_o | output | 1 | Primary output clock |
| clk2_o | output | 1 | Secondary output clock |
| clk_oe_o | output | 1 | Output enable; low in power-down |

## Verification
Four things are checked on every cycle: the length of the high run of the reference, feedback and primary dividers against their active ratio, the rule that an active ratio changes only in the cycle after a terminal count, the rule that the halved primary clock toggles only on a primary rising edge, and the forced-low outputs in power-down and in the off mode. The bench's scenarios are the only place that shows whole periods measured against the configuration words. They alone show a mid-period change completing the old period, the reference pass-through on both clock phases, and the compare clocks running on through power-down.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Secondary output function codes
  typedef enum logic [1:0] {
    C2_REF      = 2'b00,
    C2_REF_HALF = 2'b01,
    C2_OFF      = 2'b10,
    C2_C1_HALF  = 2'b11
  } clk2_fn_e;

  // Offsets of the coded ratio words
  localparam int REF_OFS = 2;
  localparam int FB_OFS  = 8;
  localparam int OUT_OFS = 2;

  // Ratio the counters run with straight out of reset
  localparam int BOOT_RATIO = 2;

  function automatic int ref_ratio(input int word);
    return word + REF_OFS;
  endfunction

  function automatic int fb_ratio(input int word);
    return word + FB_OFS;
  endfunction

  function automatic int out_ratio(input int word);
    return word + OUT_OFS;
  endfunction

  // Length of the high phase: the larger half of the period
  function automatic int high_len(input int ratio);
    return (ratio + 1) / 2;
  endfunction

endpackage

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int RW        = 8,
  parameter int BOOT      = clkdiv_pkg::BOOT_RATIO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_i,
  output logic          div_o,
  output logic          tc_o,
  output logic [RW-1:0] act_o
);
  localparam logic [RW-1:0] BOOT_V = RW'(BOOT);
  localparam logic [RW-1:0] BOOT_L = RW'(BOOT - 1);
  localparam logic [RW-1:0] MIN_V  = RW'(2);

  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] act_q, act_d;
  logic [RW-1:0] hi_d;
  logic          out_q, out_d;
  logic          wrap;

  // Last count of the running period
  assign wrap = (cnt_q == (act_q - 1'b1));

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      act_d = (ratio_i < MIN_V) ? MIN_V : ratio_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
      act_d = act_q;
    end
    hi_d  = RW'(clkdiv_pkg::high_len(int'(act_d)));
    out_d = (cnt_d < hi_d);
  end

  // Reset parks the counter on its last count so the first edge loads
  // the configured ratio and starts a clean period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= BOOT_L;
      act_q <= BOOT_V;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      out_q <= out_d;
    end
  end

  assign div_o = out_q;
  assign tc_o  = wrap;
  assign act_o = act_q;
endmodule

// File: rtl/clkdiv_toggle.sv
`timescale 1ns/1ps
module clkdiv_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (en_i) q <= ~q;
  end

  assign q_o = q;
endmodule

// File: rtl/clkdiv_out_sel.sv
`timescale 1ns/1ps
module clkdiv_out_sel (
  input  logic [1:0] fn_i,
  input  logic       pd_n,
  input  logic       ref_clk_i,
  input  logic       ref_half_i,
  input  logic       c1_i,
  input  logic       c1_half_i,
  output logic       clk1_o,
  output logic       clk2_o,
  output logic       oe_o
);
  import clkdiv_pkg::*;

  clk2_fn_e fn;
  logic     c2_raw;

  assign fn = clk2_fn_e'(fn_i);

  always_comb begin
    unique case (fn)
      C2_REF:      c2_raw = ref_clk_i;
      C2_REF_HALF: c2_raw = ref_half_i;
      C2_OFF:      c2_raw = 1'b0;
      C2_C1_HALF:  c2_raw = c1_half_i;
      default:     c2_raw = 1'b0;
    endcase
  end

  // Disabled state: outputs forced low, enable dropped
  assign oe_o   = pd_n;
  assign clk1_o = pd_n & c1_i;
  assign clk2_o = pd_n & c2_raw;
endmodule

// File: rtl/clkgen_divchain.sv
`timescale 1ns/1ps
module clkgen_divchain #(
  parameter int REF_W = 7,
  parameter int FB_W  = 9,
  parameter int OUT_W = 3
) (
  input  logic             ref_clk,
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [REF_W-1:0] ref_div_i,
  input  logic [FB_W-1:0]  fb_div_i,
  input  logic [OUT_W-1:0] out_div_i,
  input  logic [1:0]       clk2_fn_i,
  output logic             refcmp_o,
  output logic             fbcmp_o,
  output logic             clk1_o,
  output logic             clk2_o,
  output logic             clk_oe_o
);
  // One extra bit covers every offset ratio (offsets stay below 2**W)
  localparam int REF_RW = REF_W + 1;
  localparam int FB_RW  = FB_W + 1;
  localparam int OUT_RW = OUT_W + 1;

  logic [REF_RW-1:0] ref_ratio, ref_act;
  logic [FB_RW-1:0]  fb_ratio,  fb_act;
  logic [OUT_RW-1:0] od_ratio,  od_act;
  logic              ref_tc, fb_tc, od_tc;
  logic              clk1_q, c1_half, ref_half;

  assign ref_ratio = REF_RW'(clkdiv_pkg::ref_ratio(int'(ref_div_i)));
  assign fb_ratio  = FB_RW'(clkdiv_pkg::fb_ratio(int'(fb_div_i)));
  assign od_ratio  = OUT_RW'(clkdiv_pkg::out_ratio(int'(out_div_i)));

  // Reference domain
  clkdiv_counter #(.RW(REF_RW)) u_ref_div (
    .clk(ref_clk), .rst_n(rst_n), .ratio_i(ref_ratio),
    .div_o(refcmp_o), .tc_o(ref_tc), .act_o(ref_act)
  );

  clkdiv_toggle u_ref_half (
    .clk(ref_clk), .rst_n(rst_n), .en_i(1'b1), .q_o(ref_half)
  );

  // Oscillator domain
  clkdiv_counter #(.RW(FB_RW)) u_fb_div (
    .clk(vco_clk), .rst_n(rst_n), .ratio_i(fb_ratio),
    .div_o(fbcmp_o), .tc_o(fb_tc), .act_o(fb_act)
  );

  clkdiv_counter #(.RW(OUT_RW)) u_out_div (
    .clk(vco_clk), .rst_n(rst_n), .ratio_i(od_ratio),
    .div_o(clk1_q), .tc_o(od_tc), .act_o(od_act)
  );

  // Toggles on the edge where the primary clock rises
  clkdiv_toggle u_c1_half (
    .clk(vco_clk), .rst_n(rst_n), .en_i(od_tc), .q_o(c1_half)
  );

  clkdiv_out_sel u_sel (
    .fn_i(clk2_fn_i), .pd_n(pd_n), .ref_clk_i(ref_clk),
    .ref_half_i(ref_half), .c1_i(clk1_q), .c1_half_i(c1_half),
    .clk1_o(clk1_o), .clk2_o(clk2_o), .oe_o(clk_oe_o)
  );
endmodule

// File: rtl/clkgen_divchain_chk.sv
`timescale 1ns/1ps
module clkgen_divchain_chk #(
  parameter int REF_RW = 8,
  parameter int FB_RW  = 10,
  parameter int OUT_RW = 4
) (
  input logic              ref_clk,
  input logic              vco_clk,
  input logic              rst_n,
  input logic              pd_n,
  input logic [1:0]        clk2_fn_i,
  input logic              refcmp_o,
  input logic              fbcmp_o,
  input logic              clk1_q,
  input logic              clk1_o,
  input logic              clk2_o,
  input logic              clk_oe_o,
  input logic              ref_tc,
  input logic [REF_RW-1:0] ref_act,
  input logic              fb_tc,
  input logic [FB_RW-1:0]  fb_act,
  input logic              od_tc,
  input logic [OUT_RW-1:0] od_act,
  input logic              c1_half
);
  logic              ref_ok, vco_ok;
  logic [REF_RW-1:0] ref_run;
  logic [FB_RW-1:0]  fb_run;
  logic [OUT_RW-1:0] od_run;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ok  <= 1'b0;
      ref_run <= '0;
    end else begin
      ref_ok  <= 1'b1;
      ref_run <= refcmp_o ? ref_run + 1'b1 : '0;
    end
  end

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      vco_ok <= 1'b0;
      fb_run <= '0;
      od_run <= '0;
    end else begin
      vco_ok <= 1'b1;
      fb_run <= fbcmp_o ? fb_run + 1'b1 : '0;
      od_run <= clk1_q  ? od_run + 1'b1 : '0;
    end
  end

  // R1 / R4: high run of the reference divider is the larger half
  a_r1_ref_high_len: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_ok && !refcmp_o && $past(refcmp_o)) |->
      (int'(ref_run) == (int'(ref_act) + 1) / 2));

  // R2: same for the feedback divider
  a_r2_fb_high_len: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (vco_ok && !fbcmp_o && $past(fbcmp_o)) |->
      (int'(fb_run) == (int'(fb_act) + 1) / 2));

  // R3: same for the primary output divider
  a_r3_od_high_len: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (vco_ok && !clk1_q && $past(clk1_q)) |->
      (int'(od_run) == (int'(od_act) + 1) / 2));

  // R5: active ratios move only right after a terminal count
  a_r5_ref_load_at_tc: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_ok && (ref_act != $past(ref_act))) |-> $past(ref_tc));

  a_r5_fb_load_at_tc: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (vco_ok && (fb_act != $past(fb_act))) |-> $past(fb_tc));

  a_r5_od_load_at_tc: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (vco_ok && (od_act != $past(od_act))) |-> $past(od_tc));

  // R9: the halved primary clock changes only as the primary clock rises
  a_r9_half_on_rise: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (vco_ok && (c1_half != $past(c1_half))) |-> (clk1_q && !$past(clk1_q)));

  // R8: off mode holds the secondary output low
  a_r8_off_low: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (clk2_fn_i == 2'b10) |-> !clk2_o);

  // R10: power-down disables both outputs
  a_r10_pd_outputs: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !pd_n |-> (!clk1_o && !clk2_o && !clk_oe_o));
endmodule

bind clkgen_divchain clkgen_divchain_chk #(
  .REF_RW(REF_RW), .FB_RW(FB_RW), .OUT_RW(OUT_RW)
) chk_i (
  .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pd_n(pd_n),
  .clk2_fn_i(clk2_fn_i), .refcmp_o(refcmp_o), .fbcmp_o(fbcmp_o),
  .clk1_q(clk1_q), .clk1_o(clk1_o), .clk2_o(clk2_o), .clk_oe_o(clk_oe_o),
  .ref_tc(ref_tc), .ref_act(ref_act), .fb_tc(fb_tc), .fb_act(fb_act),
  .od_tc(od_tc), .od_act(od_act), .c1_half(c1_half)
);

// File: tb/clkgen_divchain_tb_top.sv
`timescale 1ns/1ps
module clkgen_divchain_tb_top;
  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       pd_n    = 1'b1;
  logic [6:0] ref_div = 7'd1;
  logic [8:0] fb_div  = 9'd4;
  logic [2:0] out_div = 3'd0;
  logic [1:0] c2_fn   = 2'b10;
  logic       refcmp, fbcmp, clk1, clk2, oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic c1_prev = 1'b0;
  logic c1_cur  = 1'b0;

  localparam int WD_LIMIT = 150000;
  localparam int RUN_MAX  = 2000;

  always #4   ref_clk = ~ref_clk;   // 125 MHz
  always #2.5 vco_clk = ~vco_clk;

  clkgen_divchain dut_i (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pd_n(pd_n),
    .ref_div_i(ref_div), .fb_div_i(fb_div), .out_div_i(out_div),
    .clk2_fn_i(c2_fn), .refcmp_o(refcmp), .fbcmp_o(fbcmp),
    .clk1_o(clk1), .clk2_o(clk2), .clk_oe_o(oe)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge ref_clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
        summary();
        $finish;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    case (w)
      0: return refcmp;
      1: return fbcmp;
      2: return clk1;
      default: return clk2;
    endcase
  endfunction

  // One sample at the falling edge of the chosen source clock
  task automatic smp(input bit on_vco, input int w, output logic s);
    if (on_vco) @(negedge vco_clk); else @(negedge ref_clk);
    s = pick(w);
    c1_prev = c1_cur;
    c1_cur  = clk1;
  endtask

  task automatic wait_rise(input bit on_vco, input int w);
    logic p, c;
    smp(on_vco, w, p);
    for (int i = 0; i < RUN_MAX; i++) begin
      smp(on_vco, w, c);
      if (!p && c) return;
      p = c;
    end
  endtask

  task automatic count_run(input bit on_vco, input int w, input logic lvl, output int n);
    logic c;
    n = 1;
    for (int i = 0; i < RUN_MAX; i++) begin
      smp(on_vco, w, c);
      if (c != lvl) return;
      n++;
    end
  endtask

  task automatic measure(input bit on_vco, input int w, output int hi, output int lo);
    wait_rise(on_vco, w);
    count_run(on_vco, w, 1'b1, hi);
    count_run(on_vco, w, 1'b0, lo);
  endtask

  // Bench view of the split: low phase is the floor half
  function automatic int lo_of(input int n);
    return n / 2;
  endfunction
  function automatic int hi_of(input int n);
    return n - lo_of(n);
  endfunction

  task automatic t_reset();
    logic s;
    repeat (3) @(negedge ref_clk);
    for (int w = 0; w < 4; w++) begin
      s = pick(w);
      check("R11 output low in reset", int'(s), 0);
    end
    check("R11 enable follows pd_n in reset", int'(oe), 1);
    @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_ref_div(input int word);
    int hi, lo, n;
    ref_div = 7'(word);
    n = word + 2;
    measure(1'b0, 0, hi, lo);
    check($sformatf("R1 R4 ref high, word %0d", word), hi, hi_of(n));
    check($sformatf("R1 R4 ref low, word %0d", word), lo, lo_of(n));
  endtask

  task automatic t_fb_div(input int word);
    int hi, lo, n;
    fb_div = 9'(word);
    n = word + 8;
    measure(1'b1, 1, hi, lo);
    check($sformatf("R2 R4 fb high, word %0d", word), hi, hi_of(n));
    check($sformatf("R2 R4 fb low, word %0d", word), lo, lo_of(n));
  endtask

  task automatic t_out_div(input int word);
    int hi, lo, n;
    out_div = 3'(word);
    n = word + 2;
    measure(1'b1, 2, hi, lo);
    check($sformatf("R3 R4 clk1 high, word %0d", word), hi, hi_of(n));
    check($sformatf("R3 R4 clk1 low, word %0d", word), lo, lo_of(n));
  endtask

  task automatic t_midchange();
    int hi, lo;
    ref_div = 7'd20;
    measure(1'b0, 0, hi, lo);
    wait_rise(1'b0, 0);
    ref_div = 7'd1;                 // change inside a ratio-22 period
    count_run(1'b0, 0, 1'b1, hi);
    count_run(1'b0, 0, 1'b0, lo);
    check("R5 old period high kept", hi, 11);
    check("R5 old period low kept", lo, 11);
    measure(1'b0, 0, hi, lo);
    check("R5 new ratio high", hi, 2);
    check("R5 new ratio low", lo, 1);
  endtask

  task automatic t_c2_ref();
    c2_fn = 2'b00;
    for (int i = 0; i < 3; i++) begin
      @(posedge ref_clk); #2;
      check("R6 clk2 high with ref", int'(clk2), 1);
      @(negedge ref_clk); #2;
      check("R6 clk2 low with ref", int'(clk2), 0);
    end
  endtask

  task automatic t_c2_refhalf();
    int hi, lo;
    c2_fn = 2'b01;
    measure(1'b0, 3, hi, lo);
    check("R7 ref/2 high", hi, 1);
    check("R7 ref/2 low", lo, 1);
  endtask

  task automatic t_c2_off();
    int highs = 0;
    logic s;
    c2_fn = 2'b10;
    for (int i = 0; i < 60; i++) begin
      smp(1'b1, 3, s);
      if (s) highs++;
    end
    check("R8 clk2 off stays low", highs, 0);
  endtask

  task automatic t_c2_c1half(input int word);
    int hi, lo;
    out_div = 3'(word);
    c2_fn = 2'b11;
    measure(1'b1, 3, hi, lo);
    check("R9 clk1/2 high", hi, word + 2);
    check("R9 clk1/2 low", lo, word + 2);
    wait_rise(1'b1, 3);
    check("R9 clk1 high at clk2 rise", int'(c1_cur), 1);
    check("R9 clk1 low before clk2 rise", int'(c1_prev), 0);
  endtask

  task automatic t_powerdown();
    int highs = 0;
    int rises = 0;
    logic last = refcmp;
    c2_fn = 2'b00;
    ref_div = 7'd1;
    @(negedge ref_clk);
    pd_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge ref_clk); #2;
      if (clk1 || clk2 || oe) highs++;
      @(negedge ref_clk);
      if (clk1 || clk2 || oe) highs++;
      if (refcmp && !last) rises++;
      last = refcmp;
    end
    check("R10 outputs and enable low in power-down", highs, 0);
    check("R10 compare clock runs in power-down", int'(rises > 5), 1);
    pd_n = 1'b1;
    #1;
    check("R10 enable back after power-down", int'(oe), 1);
  endtask

  initial begin
    t_reset();
    t_ref_div(1);
    t_ref_div(127);
    t_ref_div(10);
    t_fb_div(4);
    t_fb_div(511);
    t_fb_div(7);
    t_out_div(0);
    t_out_div(7);
    t_out_div(3);
    t_midchange();
    t_c2_ref();
    t_c2_refhalf();
    t_c2_off();
    t_c2_c1half(3);
    t_powerdown();
    summary();
    $finish;
  end
endmodule